// File: doc/BRIEF.md
# Dual Cascadable 8-bit Timer/Counter

The block holds two 8-bit up-counters that software can load and read back over a simple register interface. Each counter picks its own count strobe: a per-counter external strobe, a slow internal strobe or a fast internal strobe. All strobes are one system-clock cycle wide, and a counter moves only on a strobe. Counter 0 also has a run control. It can be halted, left running, or gated by one of two external level signals. When a gated run is stopped by the selected gate going low, the block raises its interrupt.

A chain bit joins the two counters into a single 16-bit counter. Counter 0 is the low byte, and its wrap from all-ones to zero advances counter 1. The set of events that raise the one sticky interrupt follows the chain bit. Unchained, a wrap of either counter or a gate stop raises it. Chained, only a gate stop or a wrap of counter 1 raises it. Two further registers drive six port pins and their per-pin output enables, so an outer pad ring can tri-state them.

Register map (3-bit address, 8-bit data): 0 counter 0, 1 counter 1, 2 control, 3 port data, 4 port output enable. The control byte is laid out as [1:0] source of counter 0, [3:2] source of counter 1, [5:4] run mode of counter 0, [6] chain, [7] interrupt (read) / clear (write).

Top module: `twin_tmr`

## Requirements
- R1: After reset both counters, the control byte, the port data, the port enables and irq_o are all zero.
- R2: A source field value of 0 selects the counter's own external strobe, 1 the slow strobe, and 2 or 3 the fast strobe. The counter advances by exactly one on the cycle after a strobe of the selected source and ignores the other strobes.
- R3: The counter 0 mode field selects how counter 0 runs. Value 0 halts it, 1 lets it run freely, 2 lets it count only while gate_i[0] is high, and 3 lets it count only while gate_i[1] is high.
- R4: In mode 2 or 3, a high-to-low change of the selected gate sets irq_o on the following cycle. A change on the unselected gate has no effect.
- R5: A write to a counter address loads wr_data_i on the next cycle and overrides an increment in the same cycle. The suppressed increment raises no wrap event and no carry.
- R6: With the chain bit at 0, each counter wraps from 8'hFF to 8'h00, and either wrap sets irq_o.
- R7: With the chain bit at 1, counter 1 advances exactly when counter 0 wraps and ignores its own source. A wrap of counter 0 alone does not set irq_o, but a wrap of counter 1 does.
- R8: irq_o stays set until a write to the control address with data bit 7 at 1. A set event in the same cycle as the clear wins. Control bit 7 reads back the flag.
- R9: Bits [5:0] written to address 3 drive port_o, and bits [5:0] written to address 4 drive port_oe_o. Both read back, with bits [7:6] reading 0.
- R10: rd_data_o shows the addressed register in the same cycle. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_i | input | 2 | External count strobe, one bit per counter |
| slow_tick_i | input | 1 | Slow internal count strobe |
| fast_tick_i | input | 1 | Fast internal count strobe |
| gate_i | input | 2 | The two selectable gate levels for counter 0 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Sticky interrupt flag |
| port_o | output | 6 | Port pin data |
| port_oe_o | output | 6 | Port pin output enables |

## Verification
The sharp collision is a software load of a counter landing in the same cycle as that counter's count strobe while it holds 8'hFF. The load must win, and neither a wrap interrupt nor a carry into the high byte may appear. The bench provokes this directly and also through random writes mixed with dense strobes, in both chained and unchained modes. A second collision is an interrupt-clear write in the cycle of a gate stop, where the flag must stay set. Every cycle is judged against a bench model of the counters, the flag and the read port.

// File: rtl/twin_tmr_pkg.sv
`timescale 1ns/1ps
package twin_tmr_pkg;
    typedef enum logic [1:0] {
        SRC_EXT   = 2'd0,
        SRC_SLOW  = 2'd1,
        SRC_FAST  = 2'd2,
        SRC_FAST2 = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        MD_HALT   = 2'd0,
        MD_RUN    = 2'd1,
        MD_GATE_A = 2'd2,
        MD_GATE_B = 2'd3
    } mode_e;

    // control byte, MSB first: clear/flag, chain, mode, source 1, source 0
    typedef struct packed {
        logic  clr_flag;
        logic  chain;
        mode_e mode;
        src_e  src1;
        src_e  src0;
    } ctrl_t;

    localparam int AW = 3;
    localparam logic [AW-1:0] A_CNT0 = 3'd0;
    localparam logic [AW-1:0] A_CNT1 = 3'd1;
    localparam logic [AW-1:0] A_CTRL = 3'd2;
    localparam logic [AW-1:0] A_PDAT = 3'd3;
    localparam logic [AW-1:0] A_POE  = 3'd4;
endpackage

// File: rtl/twin_tmr_src.sv
`timescale 1ns/1ps
module twin_tmr_src
    import twin_tmr_pkg::*;
(
    input  src_e sel_i,
    input  logic ext_i,
    input  logic slow_i,
    input  logic fast_i,
    output logic tick_o
);
    always_comb begin
        case (sel_i)
            SRC_EXT:  tick_o = ext_i;
            SRC_SLOW: tick_o = slow_i;
            default:  tick_o = fast_i;
        endcase
    end
endmodule

// File: rtl/twin_tmr_gate.sv
`timescale 1ns/1ps
module twin_tmr_gate
    import twin_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gate_i,
    input  mode_e      mode_i,
    output logic       run_o,
    output logic       stop_ev_o
);
    typedef struct packed {
        logic [1:0] prev;
    } gst_t;

    gst_t gs_d, gs_q;
    logic gated, lvl_now, lvl_was;

    always_comb begin
        gs_d      = gs_q;
        gs_d.prev = gate_i;
        gated     = (mode_i == MD_GATE_A) || (mode_i == MD_GATE_B);
        lvl_now   = (mode_i == MD_GATE_B) ? gate_i[1]    : gate_i[0];
        lvl_was   = (mode_i == MD_GATE_B) ? gs_q.prev[1] : gs_q.prev[0];
        run_o     = (mode_i == MD_RUN) || (gated && lvl_now);
        stop_ev_o = gated && lvl_was && !lvl_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gs_q <= '0;
        else        gs_q <= gs_d;
    end
endmodule

// File: rtl/twin_tmr_core.sv
`timescale 1ns/1ps
module twin_tmr_core #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick0_i,
    input  logic          tick1_i,
    input  logic          run0_i,
    input  logic          stop_ev_i,
    input  logic          chain_i,
    input  logic          ld0_i,
    input  logic          ld1_i,
    input  logic [CW-1:0] ld_val_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt0_o,
    output logic [CW-1:0] cnt1_o,
    output logic          flag_o
);
    localparam logic [CW-1:0] ALL1 = '1;
    localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CW-1:0] c0;
        logic [CW-1:0] c1;
        logic          flag;
    } cst_t;

    cst_t cs_d, cs_q;
    logic inc0, wrap0, inc1, wrap1, hit;

    always_comb begin
        cs_d  = cs_q;
        // a load in the same cycle suppresses the step and its wrap
        inc0  = tick0_i && run0_i && !ld0_i;
        wrap0 = inc0 && (cs_q.c0 == ALL1);
        inc1  = (chain_i ? wrap0 : tick1_i) && !ld1_i;
        wrap1 = inc1 && (cs_q.c1 == ALL1);
        hit   = stop_ev_i || wrap1 || (wrap0 && !chain_i);

        if (ld0_i)     cs_d.c0 = ld_val_i;
        else if (inc0) cs_d.c0 = cs_q.c0 + ONE;

        if (ld1_i)     cs_d.c1 = ld_val_i;
        else if (inc1) cs_d.c1 = cs_q.c1 + ONE;

        if (hit)        cs_d.flag = 1'b1;
        else if (clr_i) cs_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign cnt0_o = cs_q.c0;
    assign cnt1_o = cs_q.c1;
    assign flag_o = cs_q.flag;
endmodule

// File: rtl/twin_tmr.sv
`timescale 1ns/1ps
module twin_tmr
    import twin_tmr_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    ext_tick_i,
    input  logic          slow_tick_i,
    input  logic          fast_tick_i,
    input  logic [1:0]    gate_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [CW-1:0] wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [CW-1:0] rd_data_o,
    output logic          irq_o,
    output logic [PW-1:0] port_o,
    output logic [PW-1:0] port_oe_o
);
    localparam int CTW = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t         ctrl;
        logic [PW-1:0] pdat;
        logic [PW-1:0] poe;
    } rst_t;

    rst_t  rg_d, rg_q;
    ctrl_t ctrl_q;
    src_e  src_sel [2];
    logic [1:0]    ticks;
    logic [CW-1:0] cnt0, cnt1;
    logic run0, stop_ev, flag, ld0, ld1, clr;

    assign ctrl_q     = rg_q.ctrl;
    assign src_sel[0] = ctrl_q.src0;
    assign src_sel[1] = ctrl_q.src1;

    assign ld0 = wr_en_i && (wr_addr_i == A_CNT0);
    assign ld1 = wr_en_i && (wr_addr_i == A_CNT1);
    assign clr = wr_en_i && (wr_addr_i == A_CTRL) && wr_data_i[CTW-1];

    always_comb begin
        rg_d = rg_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CTRL: begin
                    rg_d.ctrl          = ctrl_t'(wr_data_i[CTW-1:0]);
                    rg_d.ctrl.clr_flag = 1'b0;
                end
                A_PDAT:  rg_d.pdat = wr_data_i[PW-1:0];
                A_POE:   rg_d.poe  = wr_data_i[PW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    for (genvar g = 0; g < 2; g++) begin : g_src
        twin_tmr_src u_src (
            .sel_i  (src_sel[g]),
            .ext_i  (ext_tick_i[g]),
            .slow_i (slow_tick_i),
            .fast_i (fast_tick_i),
            .tick_o (ticks[g])
        );
    end

    twin_tmr_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate_i    (gate_i),
        .mode_i    (ctrl_q.mode),
        .run_o     (run0),
        .stop_ev_o (stop_ev)
    );

    twin_tmr_core #(.CW(CW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick0_i   (ticks[0]),
        .tick1_i   (ticks[1]),
        .run0_i    (run0),
        .stop_ev_i (stop_ev),
        .chain_i   (ctrl_q.chain),
        .ld0_i     (ld0),
        .ld1_i     (ld1),
        .ld_val_i  (wr_data_i),
        .clr_i     (clr),
        .cnt0_o    (cnt0),
        .cnt1_o    (cnt1),
        .flag_o    (flag)
    );

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CNT0: rd_data_o = cnt0;
            A_CNT1: rd_data_o = cnt1;
            A_CTRL: begin
                rd_data_o[CTW-1:0] = ctrl_q;
                rd_data_o[CTW-1]   = flag;
            end
            A_PDAT:  rd_data_o[PW-1:0] = rg_q.pdat;
            A_POE:   rd_data_o[PW-1:0] = rg_q.poe;
            default: ;
        endcase
    end

    assign irq_o     = flag;
    assign port_o    = rg_q.pdat;
    assign port_oe_o = rg_q.poe;
endmodule

// File: rtl/twin_tmr_chk.sv
`timescale 1ns/1ps
module twin_tmr_chk
    import twin_tmr_pkg::*;
#(
    parameter int CW = 8,
    parameter int PW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en_i,
    input logic [AW-1:0] wr_addr_i,
    input logic [CW-1:0] wr_data_i,
    input logic          irq_o,
    input logic [PW-1:0] port_o,
    input ctrl_t         ctrl_q,
    input logic [CW-1:0] cnt0,
    input logic [CW-1:0] cnt1
);
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode == MD_HALT && !(wr_en_i && wr_addr_i == A_CNT0)) |=> $stable(cnt0)); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_CNT0) |=> (cnt0 == $past(wr_data_i))); // R5

    AST_CHAIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.chain && !(wr_en_i && wr_addr_i == A_CNT1))
        |=> ((cnt1 == $past(cnt1)) || (cnt0 == '0))); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en_i && wr_addr_i == A_CTRL && wr_data_i[7])) |=> irq_o); // R8

    AST_PORT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_PDAT) |=> (port_o == $past(wr_data_i[PW-1:0]))); // R9
endmodule

bind twin_tmr twin_tmr_chk #(.CW(CW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .irq_o     (irq_o),
    .port_o    (port_o),
    .ctrl_q    (ctrl_q),
    .cnt0      (cnt0),
    .cnt1      (cnt1)
);

// File: tb/sim_twin_tmr.sv
`timescale 1ns/1ps
module sim_twin_tmr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext = '0;
    logic       slow = 1'b0, fast = 1'b0;
    logic [1:0] gate = '0;
    logic       we = 1'b0;
    logic [2:0] wa = '0, ra = '0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic       irq;
    logic [5:0] pout, poe;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [7:0] m_c0 = '0, m_c1 = '0, m_ctrl = '0;
    logic       m_flag = 1'b0;
    logic [5:0] m_pd = '0, m_poe = '0;
    logic [1:0] m_gp = '0;

    always #4 clk = ~clk;

    twin_tmr u0 (
        .clk(clk), .rst_n(rst_n), .ext_tick_i(ext), .slow_tick_i(slow),
        .fast_tick_i(fast), .gate_i(gate), .wr_en_i(we), .wr_addr_i(wa),
        .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq),
        .port_o(pout), .port_oe_o(poe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic pick(logic [1:0] s, logic e, logic sl, logic f);
        return (s == 2'd0) ? e : (s == 2'd1) ? sl : f;
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_c0;
            3'd1: return m_c1;
            3'd2: return {m_flag, m_ctrl[6:0]};
            3'd3: return {2'b00, m_pd};
            3'd4: return {2'b00, m_poe};
            default: return 8'h00;
        endcase
    endfunction

    // one clock: predict from current inputs, advance, compare
    task automatic cyc();
        logic [1:0] md;
        logic t0, t1, lvl, was, en0, stop, w0, w1, st0, car, st1, ov1, nf;
        logic [7:0] n0, n1, nc;
        logic [5:0] npd, npoe;
        md   = m_ctrl[5:4];
        t0   = pick(m_ctrl[1:0], ext[0], slow, fast);
        t1   = pick(m_ctrl[3:2], ext[1], slow, fast);
        lvl  = (md == 2'd3) ? gate[1] : gate[0];
        was  = (md == 2'd3) ? m_gp[1] : m_gp[0];
        en0  = (md == 2'd1) || (md[1] && lvl);
        stop = md[1] && was && !lvl;
        w0   = we && wa == 3'd0;
        w1   = we && wa == 3'd1;
        st0  = t0 && en0 && !w0;
        car  = st0 && (m_c0 == 8'hFF);
        st1  = (m_ctrl[6] ? car : t1) && !w1;
        ov1  = st1 && (m_c1 == 8'hFF);
        n0   = w0 ? wd : (st0 ? m_c0 + 8'd1 : m_c0);
        n1   = w1 ? wd : (st1 ? m_c1 + 8'd1 : m_c1);
        if (stop || ov1 || (car && !m_ctrl[6])) nf = 1'b1;
        else if (we && wa == 3'd2 && wd[7])     nf = 1'b0;
        else                                    nf = m_flag;
        nc   = (we && wa == 3'd2) ? {1'b0, wd[6:0]} : m_ctrl;
        npd  = (we && wa == 3'd3) ? wd[5:0] : m_pd;
        npoe = (we && wa == 3'd4) ? wd[5:0] : m_poe;
        @(posedge clk);
        #1;
        m_c0 = n0; m_c1 = n1; m_flag = nf; m_ctrl = nc;
        m_pd = npd; m_poe = npoe; m_gp = gate;
        chk("R8 irq", {31'd0, irq}, {31'd0, m_flag});
        chk("R9 port", {26'd0, pout}, {26'd0, m_pd});
        chk("R9 oe", {26'd0, poe}, {26'd0, m_poe});
        chk("R10 rd", {24'd0, rd}, {24'd0, exp_rd(ra)});
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        we = 1'b1; wa = a; wd = d;
        cyc();
        we = 1'b0;
    endtask

    task automatic rdchk(string req, logic [2:0] a, logic [7:0] exp);
        ra = a;
        #1;
        chk(req, {24'd0, rd}, {24'd0, exp});
    endtask

    task automatic tick_slow();
        slow = 1'b1; cyc(); slow = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 port", {26'd0, pout}, 32'd0);
        chk("R1 oe", {26'd0, poe}, 32'd0);
        for (int a = 0; a < 5; a++) rdchk("R1 reg", 3'(a), 8'h00);
        rst_n = 1'b1;
        cyc();

        // R2 source select: counter 0 on slow strobe, mode run
        wr(3'd2, 8'h11);
        ext = 2'b11; fast = 1'b1; cyc(); ext = '0; fast = 1'b0;
        rdchk("R2 other strobes ignored", 3'd0, 8'h00);
        tick_slow();
        rdchk("R2 slow strobe counts", 3'd0, 8'h01);

        // R3 halt
        wr(3'd2, 8'h01);
        tick_slow();
        rdchk("R3 halted", 3'd0, 8'h01);

        // R5 load against increment at all-ones
        wr(3'd2, 8'h11);
        wr(3'd0, 8'hFF);
        slow = 1'b1; we = 1'b1; wa = 3'd0; wd = 8'h42; cyc();
        slow = 1'b0; we = 1'b0;
        rdchk("R5 load wins", 3'd0, 8'h42);
        chk("R5 no wrap flag", {31'd0, irq}, 32'd0);

        // R6 counter 0 wrap, R8 sticky and clear
        wr(3'd0, 8'hFF);
        tick_slow();
        rdchk("R6 wrap to zero", 3'd0, 8'h00);
        chk("R6 wrap0 flag", {31'd0, irq}, 32'd1);
        cyc();
        chk("R8 sticky", {31'd0, irq}, 32'd1);
        rdchk("R8 flag readback", 3'd2, 8'h91);
        wr(3'd2, 8'h91);
        chk("R8 cleared", {31'd0, irq}, 32'd0);

        // R6 counter 1 wrap on fast strobe
        wr(3'd2, 8'h19);
        wr(3'd1, 8'hFF);
        fast = 1'b1; cyc(); fast = 1'b0;
        rdchk("R6 cnt1 wrap", 3'd1, 8'h00);
        chk("R6 wrap1 flag", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'h91);

        // R7 chained
        wr(3'd2, 8'h51);
        wr(3'd1, 8'h7F);
        wr(3'd0, 8'hFF);
        slow = 1'b1; ext = 2'b10; cyc(); slow = 1'b0; ext = '0;
        rdchk("R7 low wraps", 3'd0, 8'h00);
        rdchk("R7 carry", 3'd1, 8'h80);
        chk("R7 no low wrap flag", {31'd0, irq}, 32'd0);
        ext = 2'b10; cyc(); ext = '0;
        rdchk("R7 own source ignored", 3'd1, 8'h80);
        wr(3'd1, 8'hFF);
        wr(3'd0, 8'hFF);
        tick_slow();
        rdchk("R7 16-bit wrap hi", 3'd1, 8'h00);
        chk("R7 high wrap flag", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'hD1);

        // R3 / R4 gate A
        wr(3'd2, 8'h21);
        gate = 2'b01; tick_slow();
        rdchk("R3 gated counts", 3'd0, 8'h01);
        gate = 2'b00; tick_slow();
        rdchk("R3 gate low holds", 3'd0, 8'h01);
        chk("R4 gate stop flag", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'hB1);
        // gate B selected: fall on gate 0 ignored
        gate = 2'b01; cyc();
        gate = 2'b00; cyc();
        chk("R4 unselected gate ignored", {31'd0, irq}, 32'd0);
        gate = 2'b10; cyc();
        gate = 2'b00; cyc();
        chk("R4 gate B stop flag", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'hA1);
        // R8 set wins over clear in same cycle
        gate = 2'b01; cyc();
        gate = 2'b00; we = 1'b1; wa = 3'd2; wd = 8'hA1; cyc(); we = 1'b0;
        chk("R8 set beats clear", {31'd0, irq}, 32'd1);
        wr(3'd2, 8'h81);

        // R9 port registers
        wr(3'd3, 8'hEA);
        wr(3'd4, 8'h15);
        chk("R9 port data", {26'd0, pout}, 32'h2A);
        chk("R9 port enable", {26'd0, poe}, 32'h15);
        rdchk("R9 data readback", 3'd3, 8'h2A);
        rdchk("R9 oe readback", 3'd4, 8'h15);

        // R10 unused addresses
        for (int a = 5; a < 8; a++) rdchk("R10 unused", 3'(a), 8'h00);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            fast = ($urandom % 2) == 0;
            slow = ($urandom % 8) == 0;
            ext  = 2'($urandom % 4) & {($urandom % 4) == 0, ($urandom % 4) == 0};
            if (($urandom % 16) == 0) gate[0] = ~gate[0];
            if (($urandom % 16) == 0) gate[1] = ~gate[1];
            we = ($urandom % 8) == 0;
            wa = 3'($urandom % 6);
            wd = 8'($urandom);
            if (($urandom % 4) != 0 && wa < 3'd2) wd = 8'hFE | 8'($urandom % 2);
            ra = 3'($urandom % 8);
            cyc();
        end
        we = 1'b0; fast = 1'b0; slow = 1'b0; ext = '0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule